// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status word of a small 8-bit processor core. After each ALU operation it takes the result and side information about the carry chain, and it updates the arithmetic flags: carry, auxiliary (nibble) carry, zero and overflow. The operation class decides which flags change and how the carry chain is read. Two sticky low-power flags sit in the same word. One records that the core entered halt, and one records that the watchdog expired. Halt, watchdog clear and watchdog expiry each set or clear these two flags in their own way.

Software can load the four arithmetic flags directly. The two low-power flags are read-only to software. The top two bits always read as zero. The word is never saved automatically when an interrupt or call is taken, so a service routine that changes flags must save and restore the word itself. All updates are registered and appear on `stat_o` one clock after the cycle that causes them. An active-low reset stands for power-up.

An operation is presented with `op_valid` for one cycle. The register takes one operation per clock and can never stall. Because of this the operation interface has no ready signal, the producer may drive a new operation on every cycle, and no back-pressure ever applies.

Top module: `status_flag_reg`

## Requirements
- R1: Reset (power-up) clears the whole status word to 0x00.
- R2: For an add (`op_kind` = 0), carry takes `op_cy`, auxiliary carry takes `op_nib_cy`, and zero is set exactly when `op_result` is all zeros. Carry is bit 0, auxiliary carry bit 1, zero bit 2.
- R3: For a subtract (`op_kind` = 1), `op_cy` and `op_nib_cy` are borrows. Carry becomes the inverse of `op_cy` and auxiliary carry the inverse of `op_nib_cy`. Zero follows the result.
- R4: For a logic operation (`op_kind` = 2), only zero is updated. Carry, auxiliary carry and overflow keep their values.
- R5: For a rotate through carry (`op_kind` = 3), carry takes the shifted-out bit on `op_cy`. Zero, auxiliary carry and overflow keep their values.
- R6: Overflow (bit 3) is updated on add and subtract. It is set when the signed result is out of range: on add, both operands have the same sign and the result sign differs from it; on subtract, the operands differ in sign and the result sign differs from the first operand's sign.
- R7: `wr_en` loads bits 0 to 3 from `wr_data[3:0]`, and `wr_data[7:4]` is ignored. A write in the same cycle as an operation takes precedence over the operation.
- R8: `halt_i` sets the power-down flag (bit 4) and clears the timeout flag (bit 5).
- R9: `wdt_clr_i` clears both the power-down flag and the timeout flag. When halt and clear arrive together, the power-down flag ends set.
- R10: `wdt_tmo_i` sets the timeout flag. When it arrives in the same cycle as a halt or a clear, the timeout flag ends set.
- R11: Bits 6 and 7 of `stat_o` always read 0.
- R12: In a cycle with no operation, no write and no power pulse, the status word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_kind | input | 2 | 0 add, 1 subtract, 2 logic, 3 rotate through carry |
| op_result | input | DATA_W | ALU result |
| op_a_msb | input | 1 | Sign bit of the first operand |
| op_b_msb | input | 1 | Sign bit of the second operand |
| op_cy | input | 1 | Carry out (add), borrow out (subtract) or shifted-out bit (rotate) |
| op_nib_cy | input | 1 | Carry out of the low nibble (add) or borrow into it (subtract) |
| wr_en | input | 1 | Software write of the status word |
| wr_data | input | 8 | Write data; only bits 3:0 are used |
| halt_i | input | 1 | Halt instruction executed |
| wdt_clr_i | input | 1 | Watchdog-clear instruction executed |
| wdt_tmo_i | input | 1 | Watchdog expired |
| stat_o | output | 8 | Status word |

## Verification
Two pairs of events can land in the same clock. A watchdog timeout can arrive with a watchdog clear or a halt, and a software write can arrive with an ALU operation. Directed steps drive each pair in one cycle, including timeout with clear and halt together. Random runs also raise the pulses and writes often enough to make such overlaps common. A behavioural model in the bench predicts the word using the precedence stated in R7, R9 and R10, and the bench compares every field after every clock.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_ROT   = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic ov;
    logic z;
    logic ac;
    logic c;
  } arith_flags_t;

  localparam int STAT_W  = 8;
  localparam int BIT_C   = 0;
  localparam int BIT_AC  = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_OV  = 3;
  localparam int BIT_PD  = 4;
  localparam int BIT_TO  = 5;
  localparam int ARITH_W = 4;
endpackage

// File: rtl/sf_arith_next.sv
module sf_arith_next
  import sf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  arith_flags_t      cur_i,
  input  op_kind_e          kind_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              a_msb_i,
  input  logic              b_msb_i,
  input  logic              cy_i,
  input  logic              nib_cy_i,
  output arith_flags_t      nxt_o
);
  localparam int MSB = DATA_W - 1;

  logic res_zero;
  logic res_msb;
  logic add_ovf;
  logic sub_ovf;

  assign res_zero = (result_i == '0);
  assign res_msb  = result_i[MSB];
  assign add_ovf  = (a_msb_i == b_msb_i) && (res_msb != a_msb_i);
  assign sub_ovf  = (a_msb_i != b_msb_i) && (res_msb != a_msb_i);

  always_comb begin
    nxt_o = cur_i;
    unique case (kind_i)
      OP_ADD: begin
        nxt_o.c  = cy_i;
        nxt_o.ac = nib_cy_i;
        nxt_o.z  = res_zero;
        nxt_o.ov = add_ovf;
      end
      OP_SUB: begin
        nxt_o.c  = ~cy_i;
        nxt_o.ac = ~nib_cy_i;
        nxt_o.z  = res_zero;
        nxt_o.ov = sub_ovf;
      end
      OP_LOGIC: begin
        nxt_o.z = res_zero;
      end
      OP_ROT: begin
        nxt_o.c = cy_i;
      end
      default: nxt_o = cur_i;
    endcase
  end

  always_comb begin
    if (kind_i == OP_LOGIC || kind_i == OP_ROT)
      assert_logic_rot_keep_ov_R4: assert (nxt_o.ov == cur_i.ov);
    if (kind_i == OP_ROT)
      assert_rot_keeps_zero_R5: assert (nxt_o.z == cur_i.z && nxt_o.ac == cur_i.ac);
  end
endmodule

// File: rtl/sf_power_flags.sv
module sf_power_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic clr_i,
  input  logic tmo_i,
  output logic pd_o,
  output logic to_o
);
  logic pd_q;
  logic to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
    end else if (halt_i) begin
      pd_q <= 1'b1;
    end else if (clr_i) begin
      pd_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b0;
    end else if (tmo_i) begin
      to_q <= 1'b1;
    end else if (halt_i || clr_i) begin
      to_q <= 1'b0;
    end
  end

  assign pd_o = pd_q;
  assign to_o = to_q;

  assert_timeout_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_i |=> to_o);
  assert_halt_sets_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !tmo_i) |=> (pd_o && !to_o));
  assert_clear_drops_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !halt_i && !tmo_i) |=> (!pd_o && !to_o));
  assert_quiet_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && !clr_i && !tmo_i) |=> ($stable(pd_o) && $stable(to_o)));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] op_result,
  input  logic              op_a_msb,
  input  logic              op_b_msb,
  input  logic              op_cy,
  input  logic              op_nib_cy,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              halt_i,
  input  logic              wdt_clr_i,
  input  logic              wdt_tmo_i,
  output logic [7:0]        stat_o
);
  arith_flags_t flags_q;
  arith_flags_t flags_nxt;
  arith_flags_t wr_flags;
  logic         pd;
  logic         to;
  op_kind_e     kind;

  assign kind     = op_kind_e'(op_kind);
  assign wr_flags = arith_flags_t'(wr_data[ARITH_W-1:0]);

  sf_arith_next #(.DATA_W(DATA_W)) u_arith (
    .cur_i    (flags_q),
    .kind_i   (kind),
    .result_i (op_result),
    .a_msb_i  (op_a_msb),
    .b_msb_i  (op_b_msb),
    .cy_i     (op_cy),
    .nib_cy_i (op_nib_cy),
    .nxt_o    (flags_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= wr_flags;
    end else if (op_valid) begin
      flags_q <= flags_nxt;
    end
  end

  sf_power_flags u_power (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt_i (halt_i),
    .clr_i  (wdt_clr_i),
    .tmo_i  (wdt_tmo_i),
    .pd_o   (pd),
    .to_o   (to)
  );

  always_comb begin
    stat_o                        = '0;
    stat_o[BIT_C]                 = flags_q.c;
    stat_o[BIT_AC]                = flags_q.ac;
    stat_o[BIT_Z]                 = flags_q.z;
    stat_o[BIT_OV]                = flags_q.ov;
    stat_o[BIT_PD]                = pd;
    stat_o[BIT_TO]                = to;
  end

  assert_top_bits_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[7:6] == 2'b00);
  assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && op_kind == 2'd2) |=> $stable(stat_o[BIT_AC:BIT_C]));
  assert_write_loads_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stat_o[3:0] == $past(wr_data[3:0])));
  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en) |=> $stable(stat_o[3:0]));
  assert_add_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && op_kind == 2'd0 && op_result == '0) |=> stat_o[BIT_Z]);
endmodule

// File: tb/status_flag_reg_tb_top.sv
`timescale 1ns/1ps
module status_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [7:0] op_result = 8'd0;
  logic       op_a_msb = 1'b0;
  logic       op_b_msb = 1'b0;
  logic       op_cy = 1'b0;
  logic       op_nib_cy = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       halt_i = 1'b0;
  logic       wdt_clr_i = 1'b0;
  logic       wdt_tmo_i = 1'b0;
  logic [7:0] stat_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  int m_c, m_ac, m_z, m_ov, m_pd, m_to;
  string tag_arith, tag_ov, tag_pd, tag_to;

  always #4 clk = ~clk;

  status_flag_reg #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_result(op_result), .op_a_msb(op_a_msb), .op_b_msb(op_b_msb),
    .op_cy(op_cy), .op_nib_cy(op_nib_cy), .wr_en(wr_en), .wr_data(wr_data),
    .halt_i(halt_i), .wdt_clr_i(wdt_clr_i), .wdt_tmo_i(wdt_tmo_i),
    .stat_o(stat_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({tag_arith, " carry"}, stat_o[0], m_c);
    chk({tag_arith, " aux carry"}, stat_o[1], m_ac);
    chk({tag_arith, " zero"}, stat_o[2], m_z);
    chk({tag_ov, " overflow"}, stat_o[3], m_ov);
    chk({tag_pd, " power-down"}, stat_o[4], m_pd);
    chk({tag_to, " timeout"}, stat_o[5], m_to);
    chk("R11 top bits", stat_o[7:6], 0);
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // kind: 0 add,1 sub,2 logic,3 rot; a,b operands (rot: a is value, b[0] carry-in unused)
  task automatic step(input bit v, input int kind, input int a, input int b,
                      input bit we, input int wd, input bit h, input bit cl, input bit tm);
    int res, cy, ncy, s;
    bit opd;
    res = 0; cy = 0; ncy = 0;
    opd = v && !we;
    tag_arith = "R12"; tag_ov = "R12"; tag_pd = "R12"; tag_to = "R12";
    case (kind)
      0: begin
        res = (a + b) & 255; cy = (a + b) > 255; ncy = ((a & 15) + (b & 15)) > 15;
        if (opd) begin
          s = sgn(a) + sgn(b);
          m_c = cy; m_ac = ncy; m_z = (res == 0); m_ov = (s > 127 || s < -128);
          tag_arith = "R2"; tag_ov = "R6";
        end
      end
      1: begin
        res = (a - b) & 255; cy = (a < b); ncy = ((a & 15) < (b & 15));
        if (opd) begin
          s = sgn(a) - sgn(b);
          m_c = !cy; m_ac = !ncy; m_z = (res == 0); m_ov = (s > 127 || s < -128);
          tag_arith = "R3"; tag_ov = "R6";
        end
      end
      2: begin
        res = a & b;
        if (opd) begin m_z = (res == 0); tag_arith = "R4"; tag_ov = "R4"; end
      end
      default: begin
        res = ((a << 1) | (b & 1)) & 255; cy = (a >> 7) & 1;
        if (opd) begin m_c = cy; tag_arith = "R5"; tag_ov = "R5"; end
      end
    endcase
    if (we) begin
      m_c = wd & 1; m_ac = (wd >> 1) & 1; m_z = (wd >> 2) & 1; m_ov = (wd >> 3) & 1;
      tag_arith = "R7"; tag_ov = "R7";
    end
    if (tm) begin m_to = 1; tag_to = "R10"; end
    else if (h || cl) begin m_to = 0; tag_to = h ? "R8" : "R9"; end
    if (h) begin m_pd = 1; tag_pd = "R8"; end
    else if (cl) begin m_pd = 0; tag_pd = "R9"; end
    op_valid = v; op_kind = kind[1:0]; op_result = res[7:0];
    op_a_msb = a[7]; op_b_msb = b[7]; op_cy = cy[0]; op_nib_cy = ncy[0];
    wr_en = we; wr_data = wd[7:0]; halt_i = h; wdt_clr_i = cl; wdt_tmo_i = tm;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_c = 0; m_ac = 0; m_z = 0; m_ov = 0; m_pd = 0; m_to = 0;
    tag_arith = "R1"; tag_ov = "R1"; tag_pd = "R1"; tag_to = "R1";
    repeat (3) @(negedge clk);
    compare_all();                       // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    // R2 add corners
    step(1, 0, 8'hFF, 8'h01, 0, 0, 0, 0, 0);   // zero, carry, aux carry
    step(1, 0, 8'h7F, 8'h01, 0, 0, 0, 0, 0);   // R6 signed overflow
    step(1, 0, 8'h12, 8'h21, 0, 0, 0, 0, 0);
    // R3 subtract corners
    step(1, 1, 8'h80, 8'h01, 0, 0, 0, 0, 0);   // R6 overflow on sub
    step(1, 1, 8'h05, 8'h05, 0, 0, 0, 0, 0);   // zero, no borrow
    step(1, 1, 8'h10, 8'h01, 0, 0, 0, 0, 0);   // nibble borrow
    step(1, 1, 8'h01, 8'h02, 0, 0, 0, 0, 0);   // borrow -> carry clear
    // R4 logic keeps carry chain flags
    step(1, 0, 8'hFF, 8'h81, 0, 0, 0, 0, 0);
    step(1, 2, 8'hF0, 8'h0F, 0, 0, 0, 0, 0);
    step(1, 2, 8'hF0, 8'h1F, 0, 0, 0, 0, 0);
    // R5 rotate
    step(1, 3, 8'h80, 8'h00, 0, 0, 0, 0, 0);
    step(1, 3, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    // R12 idle
    step(0, 0, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    // R7 write; upper bits ignored; write beats op
    step(0, 0, 0, 0, 1, 8'hFA, 0, 0, 0);
    step(1, 0, 8'h01, 8'h01, 1, 8'h05, 0, 0, 0);
    // R8 halt, R10 timeout, R9 clear
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R10 timeout with clear, timeout with halt, all three
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1);
    // R9 halt with clear
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], $urandom_range(0, 255), $urandom_range(0, 255),
           (r[7:4] == 0), $urandom_range(0, 255),
           (r[10:8] == 0), (r[13:11] == 0), (r[16:14] == 0));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule